// File: doc/BRIEF.md
# Bus Arbitration and Target Selection Controller

This block is the initiator side of a parallel SCSI bus connection. It is used by a host controller when it wants to take the bus and address one target device. A one-cycle start pulse gives the initiator's own ID, the target's ID and a flag asking for the attention line. The block then competes for the bus, selects the target and reports one of three outcomes.

The bus lines are handled in open-drain style. Each output is an enable that pulls a line to its asserted level. Each input is the wired-OR state of the line as seen on the bus. The block checks that the bus is free, drives its own ID bit, holds the bus for the arbitration delay and compares the IDs it sees. If it wins, it raises the select line, puts both ID bits on the data lines, releases the busy line and polls for the target to answer.

Every interval is computed in clock cycles from a clock-frequency parameter and a nanosecond value. A system bench can therefore shorten the delays without changing the logic. All bus inputs pass through two-flop synchronizers before any decision is made on them.

Top module: `scsi_sel_ctrl`

## Requirements
- R1: If the synchronized busy or select line is asserted when a start is accepted, `done` pulses on the next cycle with `result` = 2 (retry), and no output enable is ever asserted.
- R2: IDs are one-hot on the 8 data lines, with bit position equal to the ID. While arbitrating, the block drives exactly its own ID bit (own ID 7 gives 0x80).
- R3: After driving its ID, the block waits up to ARB_WAIT cycles for both busy and select to be seen free. If they are not free in that time, it releases every line and returns retry.
- R4: Once the bus is free, the block asserts busy for ARB_DELAY cycles and then samples the data lines. If any bit above its own ID bit is set, it releases every line and returns retry. Bits below its own ID bit do not stop it.
- R5: On winning, select and busy are asserted together for DESKEW cycles. The attention enable follows the with-attention flag from then on.
- R6: After the deskew interval, the data lines carry the OR of the own and target ID bits and busy is released. A settle interval of SETTLE cycles follows.
- R7: The target's busy line is then checked once, straight away, and again every POLL_STEP cycles. When it is seen asserted, the block releases select and the data lines, keeps attention as requested, and returns `result` = 1 (success). Select is released SETTLE + k*POLL_STEP + 1 cycles after busy was released, where k is the index of the check that succeeded.
- R8: If none of the POLL_MAX checks sees busy, the block releases select, attention and the data lines and returns `result` = 3 (device down).
- R9: `done` is high for exactly one cycle per operation, and `busy` is high from the accepted start until the outcome. A start while `busy` is ignored. `result` holds its value until the next accepted start, which clears it to 0.
- R10: After reset, every output enable, `busy`, `done` and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, accepted only when idle |
| init_id | input | 3 | Own ID number |
| targ_id | input | 3 | Target ID number |
| with_atn | input | 1 | Assert attention once selection begins |
| bsy_in | input | 1 | Bus busy line state, asserted high |
| sel_in | input | 1 | Bus select line state, asserted high |
| data_in | input | 8 | Bus data lines state, asserted high |
| bsy_oe | output | 1 | Pull busy line |
| sel_oe | output | 1 | Pull select line |
| atn_oe | output | 1 | Pull attention line |
| data_oe | output | 8 | Per-bit pull of data lines |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle outcome strobe |
| result | output | 2 | 0 none, 1 success, 2 retry, 3 device down |

## Verification
The assertions take the inputs to be wired-OR images of the block's own enables plus other bus agents. They also assume that a responding target only raises busy after selection has started. The stimulus meets both conditions. The bench builds each input line as the OR of the block's enables and its own agent models. It releases every foreign drive between runs and waits several cycles so the synchronizers have drained before the next start. Competing arbiters in the bench drive only data bits and never busy, so arbitration is decided by the ID compare alone. The R3 case raises select exactly one cycle before the start, so that the idle check sees the bus free and the wait phase sees it taken.

// File: rtl/scsi_sel_pkg.sv
// Shared types and helpers for the arbitration and selection controller.
// Assumes time values are given in nanoseconds and the clock in Hz.
package scsi_sel_pkg;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_OK    = 2'd1,
        RES_RETRY = 2'd2,
        RES_DOWN  = 2'd3
    } sel_result_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB_WAIT,
        ST_ARB_HOLD,
        ST_DESKEW,
        ST_SETTLE,
        ST_POLL
    } sel_state_e;

    // Rounds a nanosecond interval up to whole clock cycles, never below one.
    function automatic longint unsigned ns_to_cycles(longint unsigned ns,
                                                     longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 0) ? 64'd1 : c;
    endfunction

endpackage

// File: rtl/bus_sync.sv
// Two-flop synchronizer for a bundle of asynchronous bus lines.
// Assumes each bit is independent; no multi-bit coherence is implied.
module bus_sync #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Shifts the raw lines through two registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/interval_timer.sv
// Loadable down counter; expired is high while the count is zero.
// Assumes the loader writes N-1 to obtain an N-cycle interval.
module interval_timer #(
    parameter int unsigned W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Loads on request, otherwise counts down and rests at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/arb_judge.sv
// Decides arbitration loss: any bus bit above the own one-hot ID bit.
// Assumes own_bit is one-hot; the own bit itself never counts as a rival.
module arb_judge #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] own_bit,
    input  logic [W-1:0] bus_bits,
    output logic         lost
);
    logic [W-1:0] above;
    logic         below_or;

    // Builds the mask of positions strictly above the own bit.
    always_comb begin
        below_or = 1'b0;
        for (int i = 0; i < W; i++) begin
            above[i] = below_or;
            below_or = below_or | own_bit[i];
        end
    end

    assign lost = |(bus_bits & above);
endmodule

// File: rtl/scsi_sel_ctrl.sv
// Initiator arbitration and target selection sequencer.
// Wins the bus, selects one target and reports success, retry or device down.
// Assumes bus inputs are the wired-OR of all agents, asserted high, and that
// the settle interval is longer than the synchronizer latency.
module scsi_sel_ctrl
    import scsi_sel_pkg::*;
#(
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned CLK_HZ       = 125_000_000,
    parameter int unsigned ARB_WAIT_NS  = 20_000,
    parameter int unsigned ARB_DELAY_NS = 2_200_000,
    parameter int unsigned DESKEW_NS    = 2_000,
    parameter int unsigned SETTLE_NS    = 2_000,
    parameter int unsigned POLL_STEP_NS = 100_000,
    parameter int unsigned POLL_MAX     = 2500,
    localparam int unsigned ID_W        = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ID_W-1:0]   init_id,
    input  logic [ID_W-1:0]   targ_id,
    input  logic              with_atn,
    input  logic              bsy_in,
    input  logic              sel_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              bsy_oe,
    output logic              sel_oe,
    output logic              atn_oe,
    output logic [DATA_W-1:0] data_oe,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result
);
    localparam longint unsigned ARBW_CYC = ns_to_cycles(64'(ARB_WAIT_NS),  64'(CLK_HZ));
    localparam longint unsigned ARBD_CYC = ns_to_cycles(64'(ARB_DELAY_NS), 64'(CLK_HZ));
    localparam longint unsigned DESK_CYC = ns_to_cycles(64'(DESKEW_NS),    64'(CLK_HZ));
    localparam longint unsigned SETL_CYC = ns_to_cycles(64'(SETTLE_NS),    64'(CLK_HZ));
    localparam longint unsigned STEP_CYC = ns_to_cycles(64'(POLL_STEP_NS), 64'(CLK_HZ));
    localparam longint unsigned MAX_A    = (ARBW_CYC > ARBD_CYC) ? ARBW_CYC : ARBD_CYC;
    localparam longint unsigned MAX_B    = (DESK_CYC > SETL_CYC) ? DESK_CYC : SETL_CYC;
    localparam longint unsigned MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam longint unsigned MAX_CYC  = (MAX_C > STEP_CYC) ? MAX_C : STEP_CYC;
    localparam int unsigned     TMR_W    = $clog2(MAX_CYC + 1);
    localparam int unsigned     PCNT_W   = $clog2(POLL_MAX + 1);

    // Synchronized bus view
    logic              bus_bsy_s, bus_sel_s;
    logic [DATA_W-1:0] bus_data_s;

    bus_sync #(.W(DATA_W + 2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bsy_in, sel_in, data_in}),
        .q     ({bus_bsy_s, bus_sel_s, bus_data_s})
    );

    // Registered state and its next values
    sel_state_e        state_q, state_d;
    sel_result_e       result_q, result_d;
    logic [DATA_W-1:0] own_q, own_d, tgt_q, tgt_d, data_oe_q, data_oe_d;
    logic              atn_req_q, atn_req_d;
    logic              bsy_oe_q, bsy_oe_d, sel_oe_q, sel_oe_d, atn_oe_q, atn_oe_d;
    logic              done_q, done_d;
    logic [PCNT_W-1:0] poll_q, poll_d;

    logic              tmr_load, tmr_done, arb_lost;
    logic [TMR_W-1:0]  tmr_val;

    interval_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    arb_judge #(.W(DATA_W)) u_judge (
        .own_bit  (own_q),
        .bus_bits (bus_data_s),
        .lost     (arb_lost)
    );

    // Sequencer next-state and next-output logic.
    always_comb begin
        state_d   = state_q;
        result_d  = result_q;
        own_d     = own_q;
        tgt_d     = tgt_q;
        atn_req_d = atn_req_q;
        bsy_oe_d  = bsy_oe_q;
        sel_oe_d  = sel_oe_q;
        atn_oe_d  = atn_oe_q;
        data_oe_d = data_oe_q;
        poll_d    = poll_q;
        done_d    = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    own_d     = DATA_W'(1) << init_id;
                    tgt_d     = DATA_W'(1) << targ_id;
                    atn_req_d = with_atn;
                    atn_oe_d  = 1'b0;
                    result_d  = RES_NONE;
                    if (bus_bsy_s || bus_sel_s) begin
                        done_d   = 1'b1;
                        result_d = RES_RETRY;
                    end else begin
                        data_oe_d = DATA_W'(1) << init_id;
                        state_d   = ST_ARB_WAIT;
                        tmr_load  = 1'b1;
                        tmr_val   = TMR_W'(ARBW_CYC - 1);
                    end
                end
            end
            ST_ARB_WAIT: begin
                if (!bus_bsy_s && !bus_sel_s) begin
                    bsy_oe_d = 1'b1;
                    state_d  = ST_ARB_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(ARBD_CYC - 1);
                end else if (tmr_done) begin
                    data_oe_d = '0;
                    state_d   = ST_IDLE;
                    done_d    = 1'b1;
                    result_d  = RES_RETRY;
                end
            end
            ST_ARB_HOLD: begin
                if (tmr_done) begin
                    if (arb_lost) begin
                        bsy_oe_d  = 1'b0;
                        data_oe_d = '0;
                        state_d   = ST_IDLE;
                        done_d    = 1'b1;
                        result_d  = RES_RETRY;
                    end else begin
                        sel_oe_d = 1'b1;
                        atn_oe_d = atn_req_q;
                        state_d  = ST_DESKEW;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(DESK_CYC - 1);
                    end
                end
            end
            ST_DESKEW: begin
                if (tmr_done) begin
                    data_oe_d = own_q | tgt_q;
                    bsy_oe_d  = 1'b0;
                    state_d   = ST_SETTLE;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(SETL_CYC - 1);
                end
            end
            ST_SETTLE: begin
                if (tmr_done) begin
                    poll_d   = PCNT_W'(POLL_MAX);
                    state_d  = ST_POLL;
                    tmr_load = 1'b1;
                    tmr_val  = '0;
                end
            end
            ST_POLL: begin
                if (tmr_done) begin
                    if (bus_bsy_s) begin
                        sel_oe_d  = 1'b0;
                        data_oe_d = '0;
                        state_d   = ST_IDLE;
                        done_d    = 1'b1;
                        result_d  = RES_OK;
                    end else if (poll_q <= PCNT_W'(1)) begin
                        sel_oe_d  = 1'b0;
                        atn_oe_d  = 1'b0;
                        data_oe_d = '0;
                        state_d   = ST_IDLE;
                        done_d    = 1'b1;
                        result_d  = RES_DOWN;
                    end else begin
                        poll_d   = poll_q - 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(STEP_CYC - 1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registers the sequencer state and every bus enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            result_q  <= RES_NONE;
            own_q     <= '0;
            tgt_q     <= '0;
            atn_req_q <= 1'b0;
            bsy_oe_q  <= 1'b0;
            sel_oe_q  <= 1'b0;
            atn_oe_q  <= 1'b0;
            data_oe_q <= '0;
            done_q    <= 1'b0;
            poll_q    <= '0;
        end else begin
            state_q   <= state_d;
            result_q  <= result_d;
            own_q     <= own_d;
            tgt_q     <= tgt_d;
            atn_req_q <= atn_req_d;
            bsy_oe_q  <= bsy_oe_d;
            sel_oe_q  <= sel_oe_d;
            atn_oe_q  <= atn_oe_d;
            data_oe_q <= data_oe_d;
            done_q    <= done_d;
            poll_q    <= poll_d;
        end
    end

    assign bsy_oe  = bsy_oe_q;
    assign sel_oe  = sel_oe_q;
    assign atn_oe  = atn_oe_q;
    assign data_oe = data_oe_q;
    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign result  = result_q;

    // R1: a busy bus at start gives an immediate retry with nothing driven
    a_r1_busy_bus_retry: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q == ST_IDLE && (bus_bsy_s || bus_sel_s))
        |=> (done && result == RES_RETRY && data_oe == '0 && !bsy_oe));

    // R2: only one ID bit is driven while holding the bus for arbitration
    a_r2_arb_single_id: assert property (@(posedge clk) disable iff (!rst_n)
        (bsy_oe && !sel_oe) |-> ($countones(data_oe) == 1));

    // R4: every retry outcome leaves the bus fully released
    a_r4_retry_released: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_RETRY) |-> (!bsy_oe && !sel_oe && !atn_oe && data_oe == '0));

    // R5: select only rises while busy is still held
    a_r5_sel_under_bsy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_oe) |-> bsy_oe);

    // R6: during selection the data lines carry one or two ID bits
    a_r6_select_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_oe && !bsy_oe) |-> ($countones(data_oe) >= 1 && $countones(data_oe) <= 2));

    // R7: success releases select and data lines
    a_r7_success_release: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_OK) |-> (!sel_oe && !bsy_oe && data_oe == '0));

    // R8: device down releases select, attention and data
    a_r8_down_release: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_DOWN) |-> (!sel_oe && !atn_oe && data_oe == '0));

    // R9: a finished operation always names an outcome, and a run keeps its target
    a_r9_done_has_result: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != RES_NONE));

    a_r9_target_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(tgt_q));

endmodule

// File: tb/scsi_sel_ctrl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module scsi_sel_ctrl_tb;
    localparam int CLK_HZ   = 125_000_000;
    localparam int ARBW     = 25;   // 200 ns
    localparam int ARBD     = 50;   // 400 ns
    localparam int DESK     = 10;   // 80 ns
    localparam int SETL     = 10;   // 80 ns
    localparam int STEP     = 20;   // 160 ns
    localparam int PMAX     = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] init_id = 3'd7;
    logic [2:0] targ_id = 3'd0;
    logic       with_atn = 1'b0;
    logic       bsy_oe, sel_oe, atn_oe, busy, done;
    logic [7:0] data_oe;
    logic [1:0] result;

    logic       oth_bsy = 1'b0, oth_sel = 1'b0;
    logic [7:0] oth_data = 8'h00;
    logic       tgt_bsy = 1'b0;
    logic       tgt_en = 1'b0;
    int         tgt_dly = 0;
    int         tgt_cnt = 0;
    logic [2:0] tgt_num = 3'd0;

    logic       bsy_in, sel_in;
    logic [7:0] data_in;
    assign bsy_in  = bsy_oe | tgt_bsy | oth_bsy;
    assign sel_in  = sel_oe | oth_sel;
    assign data_in = data_oe | oth_data;

    always #4 clk = ~clk;

    scsi_sel_ctrl #(
        .DATA_W(8), .CLK_HZ(CLK_HZ), .ARB_WAIT_NS(200), .ARB_DELAY_NS(400),
        .DESKEW_NS(80), .SETTLE_NS(80), .POLL_STEP_NS(160), .POLL_MAX(PMAX)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .init_id(init_id),
        .targ_id(targ_id), .with_atn(with_atn), .bsy_in(bsy_in),
        .sel_in(sel_in), .data_in(data_in), .bsy_oe(bsy_oe), .sel_oe(sel_oe),
        .atn_oe(atn_oe), .data_oe(data_oe), .busy(busy), .done(done),
        .result(result)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // Target model: raises busy a set number of cycles after seeing itself selected.
    always @(negedge clk) begin
        if (!tgt_en) begin
            tgt_cnt <= 0;
            tgt_bsy <= 1'b0;
        end else if (sel_oe && !bsy_oe && data_oe[tgt_num]) begin
            if (tgt_cnt >= tgt_dly) tgt_bsy <= 1'b1;
            tgt_cnt <= tgt_cnt + 1;
        end
    end

    // Phase monitor: counts cycles in each drive pattern.
    bit         mon_clr = 1'b0;
    int         n_arbw, n_arbd, n_desk, n_selw, n_done, n_any;
    logic [7:0] arb_data, sel_data;
    logic       desk_atn;
    always @(negedge clk) begin
        if (mon_clr) begin
            n_arbw = 0; n_arbd = 0; n_desk = 0; n_selw = 0; n_done = 0; n_any = 0;
            arb_data = 8'h00; sel_data = 8'h00; desk_atn = 1'b0;
        end else begin
            if (data_oe != 0 && !bsy_oe && !sel_oe) n_arbw++;
            if (bsy_oe && !sel_oe) begin n_arbd++; arb_data = data_oe; end
            if (bsy_oe && sel_oe) begin n_desk++; desk_atn = atn_oe; end
            if (sel_oe && !bsy_oe) begin n_selw++; sel_data = data_oe; end
            if (bsy_oe || sel_oe || atn_oe || data_oe != 0) n_any++;
            if (done) n_done++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
    endtask

    task automatic idle_gap();
        tgt_en = 1'b0; oth_bsy = 1'b0; oth_sel = 1'b0; oth_data = 8'h00;
        repeat (6) @(negedge clk);
        clear_mon();
    endtask

    task automatic pulse_start(input logic [2:0] own, input logic [2:0] tgt, input logic atn);
        init_id = own; targ_id = tgt; with_atn = atn; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit got);
        int k;
        got = 1'b0;
        k = 0;
        while (!done && k < 3000) begin
            @(negedge clk);
            k++;
        end
        got = done;
    endtask

    task automatic t_reset();
        chk(!bsy_oe && !sel_oe && !atn_oe && data_oe == 0 && !busy && !done && result == 0,
            "R10 reset outputs", {bsy_oe, sel_oe, atn_oe, busy, done}, 0);
    endtask

    task automatic t_bus_busy();
        bit got;
        idle_gap();
        oth_bsy = 1'b1;
        repeat (4) @(negedge clk);
        pulse_start(3'd7, 3'd2, 1'b0);
        chk(done && result == 2, "R1 retry on busy bus", result, 2);
        repeat (3) @(negedge clk);
        chk(n_any == 0, "R1 nothing driven", n_any, 0);
        chk(result == 2, "R9 result held after done", result, 2);
        got = 1'b0;
    endtask

    task automatic t_arb_wait_timeout();
        bit got;
        idle_gap();
        oth_sel = 1'b1;
        @(negedge clk);
        pulse_start(3'd7, 3'd2, 1'b0);
        wait_done(got);
        chk(got && result == 2, "R3 retry when bus never free", result, 2);
        @(negedge clk);
        chk(n_arbw == ARBW, "R3 wait length", n_arbw, ARBW);
        chk(n_arbd == 0 && data_oe == 0 && !bsy_oe, "R3 released", data_oe, 0);
    endtask

    task automatic t_select(input logic [2:0] own, input logic [2:0] tgt, input logic atn,
                            input int dly, input int exp_sel);
        bit got;
        idle_gap();
        tgt_num = tgt; tgt_dly = dly; tgt_en = 1'b1;
        pulse_start(own, tgt, atn);
        chk(busy, "R9 busy after start", busy, 1);
        wait_done(got);
        chk(got && result == 1, "R7 success result", result, 1);
        @(negedge clk);
        chk(n_done == 1, "R9 single done pulse", n_done, 1);
        chk(arb_data == (8'h01 << own), "R2 own ID bit in arbitration", arb_data, 8'h01 << own);
        chk(n_arbd == ARBD, "R4 arbitration delay length", n_arbd, ARBD);
        chk(n_desk == DESK, "R5 deskew length", n_desk, DESK);
        chk(desk_atn == atn, "R5 attention follows flag", desk_atn, atn);
        chk(sel_data == ((8'h01 << own) | (8'h01 << tgt)), "R6 selection ID bits",
            sel_data, (8'h01 << own) | (8'h01 << tgt));
        chk(n_selw == exp_sel, "R7 select release timing", n_selw, exp_sel);
        chk(!sel_oe && data_oe == 0 && !bsy_oe && atn_oe == atn, "R7 lines after success",
            {sel_oe, bsy_oe, atn_oe}, {1'b0, 1'b0, atn});
    endtask

    task automatic t_arb_rival(input logic [7:0] rival, input bit expect_win);
        bit got;
        int k;
        idle_gap();
        tgt_num = 3'd1; tgt_dly = 0; tgt_en = 1'b1;
        pulse_start(3'd5, 3'd1, 1'b0);
        k = 0;
        while (!bsy_oe && k < 100) begin @(negedge clk); k++; end
        oth_data = rival;
        k = 0;
        while (!sel_oe && !done && k < 200) begin @(negedge clk); k++; end
        oth_data = 8'h00;
        wait_done(got);
        if (expect_win) begin
            chk(got && result == 1, "R4 lower rival does not stop win", result, 1);
        end else begin
            chk(got && result == 2, "R4 higher rival loses arbitration", result, 2);
            @(negedge clk);
            chk(n_desk == 0 && !bsy_oe && data_oe == 0, "R4 lost releases bus", n_desk, 0);
        end
    endtask

    task automatic t_device_down();
        bit got;
        idle_gap();
        pulse_start(3'd7, 3'd4, 1'b1);
        wait_done(got);
        chk(got && result == 3, "R8 device down result", result, 3);
        @(negedge clk);
        chk(n_selw == SETL + (PMAX - 1) * STEP + 1, "R8 full poll window",
            n_selw, SETL + (PMAX - 1) * STEP + 1);
        chk(!sel_oe && !atn_oe && data_oe == 0, "R8 released incl attention",
            {sel_oe, atn_oe}, 0);
    endtask

    task automatic t_start_ignored();
        bit got;
        idle_gap();
        tgt_num = 3'd2; tgt_dly = 0; tgt_en = 1'b1;
        pulse_start(3'd7, 3'd2, 1'b0);
        repeat (5) @(negedge clk);
        pulse_start(3'd3, 3'd5, 1'b1);
        wait_done(got);
        @(negedge clk);
        chk(got && result == 1, "R9 run unaffected by second start", result, 1);
        chk(sel_data == 8'h84 && desk_atn == 1'b0, "R9 ignored start kept IDs", sel_data, 8'h84);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_bus_busy();
        t_arb_wait_timeout();
        t_select(3'd7, 3'd2, 1'b1, 0, SETL + 1);
        t_select(3'd7, 3'd0, 1'b0, 40, SETL + 2 * STEP + 1);
        t_arb_rival(8'h40, 1'b0);
        t_arb_rival(8'h08, 1'b1);
        t_device_down();
        t_start_ignored();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule